// File: doc/BRIEF.md
# Clock Input Selection Controller

This block picks which of four reference clock inputs feeds a downstream clock-recovery loop. Clock qualification happens elsewhere; the controller sees one synchronous validity flag per input, plus a per-input enable and a small priority value for each input. From these it produces a registered active-input index, a holdover request that tells the loop to coast when no usable reference exists, and a one-cycle pulse whenever the active index changes.

Two selection styles exist. In manual mode a 2-bit code picks the input, taken either from two select pins or from a register-held field, depending on a source bit. In automatic mode the controller chooses among the eligible inputs by priority. A revertive policy always moves to the best eligible input. A non-revertive policy stays on the current input while it remains eligible. A zero-delay option dedicates the last input to feedback, which removes it from every kind of selection.

All outputs come from flops. Any change on the inputs shows on the outputs after exactly one clock.

Top module: `clksel_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `active` is 0, `holdover` is 1, and `switch_pls` and `rsvd_err` are 0.
- R2: In manual mode with a non-reserved code, one clock later `active` equals the code: 0 selects input 0, 1 selects input 1, 2 selects input 2, 3 selects input 3.
- R3: In manual mode the code is taken from `sel_pin` when `src_reg` is 0 and from `sel_reg` when `src_reg` is 1.
- R4: In manual mode with `zero_dly` high, code 3 is reserved. The previous `active` is kept and `rsvd_err` is set one clock later.
- R5: `rsvd_err` stays set until reset.
- R6: In manual mode with a non-reserved code, one clock later `holdover` equals the inverse of `valid` of the selected input.
- R7: In automatic mode, when no input is eligible, one clock later `holdover` is 1 and `active` is unchanged.
- R8: In automatic mode an input is eligible only if its `valid` bit and its `auto_en` bit are both set, and it is not input 3 while `zero_dly` is high. When any input is eligible, one clock later `holdover` is 0 and `active` is an input that was eligible. This includes the cycle in which holdover is left.
- R9: With `revertive` high, the automatic choice is the eligible input with the lowest priority value. Input i's priority is `prio[2i+1:2i]`. On equal values the lower index wins.
- R10: With `revertive` low, `active` does not change while holdover is 0 and the active input stays eligible, even when a better input becomes eligible.
- R11: With `revertive` low, when the active input loses eligibility (or on leaving holdover), the choice follows the rule of R9.
- R12: `switch_pls` is 1 for exactly the cycles in which `active` differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_mode | input | 1 | 1 selects automatic mode, 0 selects manual mode |
| revertive | input | 1 | Automatic policy: 1 revertive, 0 non-revertive |
| zero_dly | input | 1 | Dedicates input 3 to feedback |
| src_reg | input | 1 | Manual code source: 0 pins, 1 register field |
| sel_pin | input | 2 | Manual code from pins |
| sel_reg | input | 2 | Manual code from register field |
| valid | input | 4 | Per-input clock validity flags |
| auto_en | input | 4 | Per-input automatic-selection enables |
| prio | input | 8 | Packed 2-bit priorities, input i at bits 2i+1:2i, lower value wins |
| active | output | 2 | Active input index |
| holdover | output | 1 | Holdover/free-run request |
| switch_pls | output | 1 | One-cycle pulse on a change of active input |
| rsvd_err | output | 1 | Sticky reserved-code error |

## Verification
The bench sweeps every manual code, source and zero-delay combination against all validity patterns. It then drives long pseudo-random validity, enable and priority sequences under both policies, with zero delay both on and off. A design that fails to exclude the feedback input would select input 3 in zero-delay mode. A design that mixes up the policies would either hop away from a still-eligible input or stick to a lost one. Directed cases target equal priorities, where a design that breaks ties wrongly picks the higher index, and a masked enable, where a design that ignores the enable picks the best raw priority. Code 3 under zero delay is also exercised, where a faulty design moves to input 3 or fails to keep the error flag.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
   typedef enum logic [1:0] {
      SEL_MANUAL   = 2'd0,
      SEL_AUTO_NR  = 2'd1,
      SEL_AUTO_REV = 2'd2
   } sel_mode_e;
endpackage

// File: rtl/clksel_elig.sv
module clksel_elig #(
   parameter int N_IN   = 4,
   parameter int FB_IDX = N_IN - 1
) (
   input  logic [N_IN-1:0] valid,
   input  logic [N_IN-1:0] auto_en,
   input  logic            zero_dly,
   output logic [N_IN-1:0] cand
);
   for (genvar i = 0; i < N_IN; i++) begin : g_in
      if (i == FB_IDX) begin : g_fb
         assign cand[i] = valid[i] & auto_en[i] & ~zero_dly;
      end else begin : g_ref
         assign cand[i] = valid[i] & auto_en[i];
      end
   end
endmodule

// File: rtl/clksel_pick.sv
module clksel_pick #(
   parameter int N_IN   = 4,
   parameter int PRIO_W = 2,
   localparam int SEL_W = $clog2(N_IN)
) (
   input  logic [N_IN-1:0]        cand,
   input  logic [N_IN*PRIO_W-1:0] prio,
   output logic                   any,
   output logic [SEL_W-1:0]       best
);
   logic [PRIO_W-1:0] pr [N_IN];
   logic [PRIO_W-1:0] bp;

   for (genvar i = 0; i < N_IN; i++) begin : g_unpack
      assign pr[i] = prio[i*PRIO_W +: PRIO_W];
   end

   always_comb begin
      any  = 1'b0;
      best = '0;
      bp   = '1;
      for (int i = 0; i < N_IN; i++) begin
         if (cand[i] && (!any || pr[i] < bp)) begin
            any  = 1'b1;
            best = SEL_W'(i);
            bp   = pr[i];
         end
      end
   end
endmodule

// File: rtl/clksel_man.sv
module clksel_man #(
   parameter int N_IN   = 4,
   parameter int FB_IDX = N_IN - 1,
   localparam int SEL_W = $clog2(N_IN)
) (
   input  logic             src_reg,
   input  logic             zero_dly,
   input  logic [SEL_W-1:0] sel_pin,
   input  logic [SEL_W-1:0] sel_reg,
   output logic [SEL_W-1:0] code,
   output logic             rsvd
);
   assign code = src_reg ? sel_reg : sel_pin;
   assign rsvd = zero_dly && (code == SEL_W'(FB_IDX));
endmodule

// File: rtl/clksel_ctrl.sv
module clksel_ctrl
   import clksel_pkg::*;
#(
   parameter int N_IN   = 4,
   parameter int PRIO_W = 2,
   localparam int SEL_W = $clog2(N_IN)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   auto_mode,
   input  logic                   revertive,
   input  logic                   zero_dly,
   input  logic                   src_reg,
   input  logic [SEL_W-1:0]       sel_pin,
   input  logic [SEL_W-1:0]       sel_reg,
   input  logic [N_IN-1:0]        valid,
   input  logic [N_IN-1:0]        auto_en,
   input  logic [N_IN*PRIO_W-1:0] prio,
   output logic [SEL_W-1:0]       active,
   output logic                   holdover,
   output logic                   switch_pls,
   output logic                   rsvd_err
);
   localparam int FB_IDX = N_IN - 1;

   if (N_IN < 2 || (1 << SEL_W) != N_IN) begin : g_bad_n
      $error("clksel_ctrl: N_IN must be a power of two, at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_p
      $error("clksel_ctrl: PRIO_W must be at least 1");
   end

   logic [N_IN-1:0]  cand;
   logic             any;
   logic [SEL_W-1:0] best, code;
   logic             rsvd;
   sel_mode_e        mode;

   logic [SEL_W-1:0] act_q, act_d;
   logic             hold_q, hold_d, err_q, err_d, sw_q;

   clksel_elig #(.N_IN(N_IN), .FB_IDX(FB_IDX)) i_elig (
      .valid(valid), .auto_en(auto_en), .zero_dly(zero_dly), .cand(cand));

   clksel_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W)) i_pick (
      .cand(cand), .prio(prio), .any(any), .best(best));

   clksel_man #(.N_IN(N_IN), .FB_IDX(FB_IDX)) i_man (
      .src_reg(src_reg), .zero_dly(zero_dly), .sel_pin(sel_pin),
      .sel_reg(sel_reg), .code(code), .rsvd(rsvd));

   always_comb begin
      if (!auto_mode)     mode = SEL_MANUAL;
      else if (revertive) mode = SEL_AUTO_REV;
      else                mode = SEL_AUTO_NR;
   end

   always_comb begin
      act_d  = act_q;
      hold_d = hold_q;
      err_d  = err_q;
      unique case (mode)
         SEL_MANUAL: begin
            if (rsvd) begin
               err_d  = 1'b1;
               hold_d = ~valid[act_q];
            end else begin
               act_d  = code;
               hold_d = ~valid[code];
            end
         end
         SEL_AUTO_NR: begin
            if (!hold_q && cand[act_q]) begin
               hold_d = 1'b0;
            end else if (any) begin
               act_d  = best;
               hold_d = 1'b0;
            end else begin
               hold_d = 1'b1;
            end
         end
         default: begin
            if (any) begin
               act_d  = best;
               hold_d = 1'b0;
            end else begin
               hold_d = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= '0;
         hold_q <= 1'b1;
         err_q  <= 1'b0;
         sw_q   <= 1'b0;
      end else begin
         act_q  <= act_d;
         hold_q <= hold_d;
         err_q  <= err_d;
         sw_q   <= (act_d != act_q);
      end
   end

   assign active     = act_q;
   assign holdover   = hold_q;
   assign switch_pls = sw_q;
   assign rsvd_err   = err_q;
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk #(
   parameter int N_IN   = 4,
   parameter int PRIO_W = 2,
   localparam int SEL_W = $clog2(N_IN)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   auto_mode,
   input logic                   revertive,
   input logic                   zero_dly,
   input logic                   src_reg,
   input logic [SEL_W-1:0]       sel_pin,
   input logic [SEL_W-1:0]       sel_reg,
   input logic [N_IN-1:0]        valid,
   input logic [N_IN-1:0]        auto_en,
   input logic [N_IN*PRIO_W-1:0] prio,
   input logic [SEL_W-1:0]       active,
   input logic                   holdover,
   input logic                   switch_pls,
   input logic                   rsvd_err
);
   logic [N_IN-1:0]        cand, cand_p;
   logic [N_IN*PRIO_W-1:0] prio_p;
   logic [SEL_W-1:0]       code_c;
   logic                   rsvd_c, better;

   always_comb begin
      for (int i = 0; i < N_IN; i++)
         cand[i] = valid[i] && auto_en[i] && !(zero_dly && i == N_IN - 1);
   end
   assign code_c = src_reg ? sel_reg : sel_pin;
   assign rsvd_c = zero_dly && (int'(code_c) == N_IN - 1);

   always_ff @(posedge clk) begin
      cand_p <= cand;
      prio_p <= prio;
   end

   always_comb begin
      better = 1'b0;
      for (int j = 0; j < N_IN; j++) begin
         if (cand_p[j] &&
             ((prio_p[j*PRIO_W +: PRIO_W] < prio_p[int'(active)*PRIO_W +: PRIO_W]) ||
              (prio_p[j*PRIO_W +: PRIO_W] == prio_p[int'(active)*PRIO_W +: PRIO_W] &&
               j < int'(active))))
            better = 1'b1;
      end
   end

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> active == '0 && holdover && !switch_pls && !rsvd_err);
   a_r2_manual_code: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode && !rsvd_c |=> active == $past(code_c));
   a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode && rsvd_c |=> $stable(active) && rsvd_err);
   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_err |=> rsvd_err);
   a_r6_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_mode && !rsvd_c |=> holdover == !$past(valid[code_c]));
   a_r7_no_elig: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode && cand == '0 |=> holdover && $stable(active));
   a_r8_elig_only: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode && |cand |=> !holdover && cand_p[active]);
   a_r9_rev_best: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode && revertive && |cand |=> !better);
   a_r10_nonrev_keep: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode && !revertive && !holdover && cand[active] |=> $stable(active));
   a_r11_failover: assert property (@(posedge clk) disable iff (!rst_n)
      auto_mode && !revertive && !(!holdover && cand[active]) && |cand |=> !better);
   a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> switch_pls == (active != $past(active)));
endmodule

bind clksel_ctrl clksel_chk #(.N_IN(N_IN), .PRIO_W(PRIO_W)) i_chk (.*);

// File: tb/test_clksel_ctrl.sv
`timescale 1ns/1ps
module test_clksel_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       auto_mode = 1'b0, revertive = 1'b0, zero_dly = 1'b0, src_reg = 1'b0;
   logic [1:0] sel_pin = '0, sel_reg = '0;
   logic [3:0] valid = '0, auto_en = '0;
   logic [7:0] prio = '0;
   logic [1:0] active;
   logic       holdover, switch_pls, rsvd_err;

   int nchk = 0, nerr = 0;
   bit done = 0;
   int m_act = 0;
   bit m_hold = 1, m_err = 0, m_sw = 0, m_err_old = 0;
   logic [15:0] lf = 16'hACE1;

   always #2 clk = ~clk;

   clksel_ctrl i_clksel_ctrl (
      .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .revertive(revertive),
      .zero_dly(zero_dly), .src_reg(src_reg), .sel_pin(sel_pin), .sel_reg(sel_reg),
      .valid(valid), .auto_en(auto_en), .prio(prio), .active(active),
      .holdover(holdover), .switch_pls(switch_pls), .rsvd_err(rsvd_err));

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic adv_lf();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   function automatic bit elig(int i);
      return valid[i] && auto_en[i] && !(zero_dly && i == 3);
   endfunction

   function automatic int pick_best();
      for (int p = 0; p < 4; p++)
         for (int i = 0; i < 4; i++)
            if (elig(i) && int'(prio[2*i +: 2]) == p) return i;
      return -1;
   endfunction

   // returns tag of requirement governing the active output for this step
   task automatic model_step(output string tag);
      int nxt, code, b;
      nxt = m_act;
      m_err_old = m_err;
      if (!auto_mode) begin
         code = src_reg ? int'(sel_reg) : int'(sel_pin);
         if (zero_dly && code == 3) begin
            m_err = 1; m_hold = !valid[m_act]; tag = "R4";
         end else begin
            nxt = code; m_hold = !valid[code];
            tag = src_reg ? "R3" : "R2";
         end
      end else begin
         b = pick_best();
         if (b < 0) begin
            m_hold = 1; tag = "R7";
         end else if (revertive) begin
            nxt = b; m_hold = 0; tag = "R9";
         end else if (!m_hold && elig(m_act)) begin
            tag = "R10";
         end else begin
            nxt = b; m_hold = 0; tag = "R11";
         end
      end
      m_sw = (nxt != m_act);
      m_act = nxt;
   endtask

   task automatic step();
      string tag;
      model_step(tag);
      @(posedge clk);
      @(negedge clk);
      chk(tag, int'(active), m_act);
      chk(auto_mode ? "R8" : "R6", int'(holdover), int'(m_hold));
      chk("R12", int'(switch_pls), int'(m_sw));
      chk(m_err_old ? "R5" : "R4", int'(rsvd_err), int'(m_err));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", int'(active), 0);
      chk("R1", int'(holdover), 1);
      chk("R1", int'(switch_pls), 0);
      chk("R1", int'(rsvd_err), 0);
      m_act = 0; m_hold = 1; m_err = 0; m_sw = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset();

      // manual mode sweep: source, zero delay, both codes, all validity
      auto_mode = 1'b0;
      for (int z = 0; z < 2; z++)
         for (int s = 0; s < 2; s++)
            for (int c = 0; c < 16; c++)
               for (int v = 0; v < 16; v++) begin
                  zero_dly = z[0]; src_reg = s[0];
                  sel_pin = c[1:0]; sel_reg = c[3:2];
                  valid = v[3:0];
                  step();
               end

      do_reset();
      // R3 directed: register source ignores pins
      auto_mode = 1'b0; zero_dly = 1'b0; src_reg = 1'b1;
      sel_reg = 2'd2; sel_pin = 2'd1; valid = 4'hF;
      step();
      chk("R3", int'(active), 2);

      // automatic sweeps
      auto_mode = 1'b1;
      for (int r = 0; r < 2; r++)
         for (int z = 0; z < 2; z++)
            for (int k = 0; k < 700; k++) begin
               revertive = r[0]; zero_dly = z[0];
               adv_lf();
               valid = lf[3:0];
               if (k % 16 == 0) begin
                  prio = lf[11:4];
                  auto_en = (lf[15:12] == 4'd0) ? 4'hF : (lf[15:12] | 4'b0101);
               end
               step();
            end

      // R9 directed: equal priorities resolve to lower index
      revertive = 1'b1; zero_dly = 1'b0; auto_en = 4'hF; valid = 4'hF;
      prio = {2'd1, 2'd1, 2'd1, 2'd1};
      step();
      chk("R9", int'(active), 0);
      // R8 directed: disabled input 0 excluded; inputs 1 and 2 tie
      prio = {2'd3, 2'd1, 2'd1, 2'd0}; auto_en = 4'b1110;
      step();
      chk("R8", int'(active), 1);
      // R8 zero delay: best input 3 is feedback
      prio = {2'd0, 2'd2, 2'd3, 2'd3}; auto_en = 4'hF; zero_dly = 1'b1;
      step();
      chk("R8", int'(active), 2);
      // R10: non-revertive stays on 2 when 3 becomes usable
      revertive = 1'b0; zero_dly = 1'b0;
      step();
      chk("R10", int'(active), 2);
      // R11: drop input 2, expect input 3 (prio 0)
      valid = 4'b1011;
      step();
      chk("R11", int'(active), 3);
      // R7: nothing valid
      valid = 4'b0000;
      step();
      chk("R7", int'(holdover), 1);
      chk("R7", int'(active), 3);
      // leave holdover onto input 1
      valid = 4'b0010;
      step();
      chk("R8", int'(active), 1);
      chk("R12", int'(switch_pls), 1);

      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule